// File: doc/BRIEF.md
# Serial Bootstrap RAM Loader

This block fills on-chip RAM from a serial byte stream when the chip comes out of reset in bootstrap mode. A UART receiver hands it one byte at a time as a data byte with a one-cycle valid strobe. The loader stores the bytes one after another through a simple synchronous RAM write port. The first byte goes to address zero.

Loading stops in one of two ways. Either the byte for the top RAM address has been stored, or the line has stayed quiet for four character times after data started. On either ending the loader raises a sticky completion flag and presents start address zero, so the CPU can begin executing the loaded program. The idle timer only starts once the first byte has arrived, so the loader can wait for a host without any time limit.

The mode input is sampled once, on the first clock edge after reset is released. The reset input is expected to be asserted asynchronously and released synchronously by the chip's reset logic. If bootstrap mode is not selected, the block stays inert until the next reset.

Top module: `serial_boot_loader`

## Requirements
- R1: The boot-select input is sampled on the first rising clock edge after reset release. If it is 0 there, the block never asserts the write enable and never raises done until the next reset, whatever the boot-select input or the receiver do later. Any strobe on that first edge is not taken.
- R2: Each accepted byte produces exactly one write. The write enable is high for one cycle, in the cycle after the edge where the valid strobe was sampled. The write carries that byte as data. The first accepted byte goes to address 0, and each later byte goes to the previous address plus one. No write occurs in any cycle without an accepted byte.
- R3: Writes never go past address RAM_DEPTH-1. The byte written to address RAM_DEPTH-1 raises done in the same cycle that its write is presented.
- R4: After an accepted byte on edge N, done rises after edge N+IDLE_LIMIT if no strobe arrives on edges N+1 through N+IDLE_LIMIT. IDLE_LIMIT is 4*CHAR_BITS*BIT_CYCLES. A strobe on edge N+IDLE_LIMIT is still accepted and restarts the count.
- R5: Before the first byte is accepted, no amount of idle time raises done.
- R6: Once raised, done stays high until reset. Strobes that arrive after done produce no write. The execution start address output reads 0.
- R7: While reset is asserted, the write enable and done are 0 and the start address output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| boot_sel_i | input | 1 | 1 = bootstrap mode selected; sampled once after reset |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | One-cycle strobe marking a new received byte |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | AW | RAM write address |
| ram_wdata_o | output | 8 | RAM write data |
| done_o | output | 1 | Sticky flag: loading has ended |
| exec_addr_o | output | AW | Address where execution starts (0) |

## Verification
A strobe sampled on edge N shows up as a write in the cycle after edge N. A final byte raises done in that same cycle. A timeout raises done exactly IDLE_LIMIT edges after the last accepted byte. The bench drives inputs on falling edges and samples 1 ns after each rising edge, so every check lands in the first cycle its result is due. It also tests the cycle before each deadline and the exact-boundary strobe. A small configuration (16-entry RAM, 80-cycle idle limit) lets the sweeps fill the whole RAM with varied gaps and run the timeouts in full.

// File: rtl/boot_ld_pkg.sv
package boot_ld_pkg;
  typedef enum logic [2:0] {
    LD_PROBE = 3'd0,
    LD_WAIT  = 3'd1,
    LD_LOAD  = 3'd2,
    LD_DONE  = 3'd3,
    LD_OFF   = 3'd4
  } ld_state_e;
endpackage

// File: rtl/boot_ld_addr.sv
module boot_ld_addr #(
  parameter int RAM_DEPTH = 256,
  parameter int AW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_i,
  output logic [AW-1:0] ptr_o,
  output logic          last_o
);
  logic [AW-1:0] ptr_q, ptr_d;

  assign last_o = (ptr_q == AW'(RAM_DEPTH - 1));

  always_comb begin
    ptr_d = ptr_q;
    if (accept_i && !last_o) ptr_d = ptr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (accept_i) ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

  p_ptr_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_i |=> $stable(ptr_q));
  p_ptr_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> $stable(ptr_q));
endmodule

// File: rtl/boot_ld_idle.sv
module boot_ld_idle #(
  parameter int IDLE_LIMIT = 640,
  parameter int CW         = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic kick_i,
  output logic expire_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_end;

  assign at_end   = (cnt_q == CW'(IDLE_LIMIT - 1));
  assign expire_o = arm_i && !kick_i && at_end;

  always_comb begin
    cnt_d = cnt_q;
    if (kick_i) cnt_d = '0;
    else if (arm_i && !at_end) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else cnt_q <= cnt_d;
  end

  p_timer_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(IDLE_LIMIT - 1));
  p_kick_restarts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> cnt_q == '0);
endmodule

// File: rtl/boot_ld_wport.sv
module boot_ld_wport #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_i,
  input  logic [AW-1:0] ptr_i,
  input  logic [7:0]    data_i,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [7:0]    wdata_o
);
  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b0;
    else we_q <= accept_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (accept_i) begin
      addr_q <= ptr_i;
      data_q <= data_i;
    end
  end

  assign we_o    = we_q;
  assign addr_o  = addr_q;
  assign wdata_o = data_q;

  p_data_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_i |=> $stable(data_q) && $stable(addr_q));
endmodule

// File: rtl/serial_boot_loader.sv
module serial_boot_loader
  import boot_ld_pkg::*;
#(
  parameter int RAM_DEPTH  = 256,
  parameter int BIT_CYCLES = 16,
  parameter int CHAR_BITS  = 10,
  localparam int AW         = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1,
  localparam int IDLE_LIMIT = 4 * CHAR_BITS * BIT_CYCLES,
  localparam int CW         = (IDLE_LIMIT > 1) ? $clog2(IDLE_LIMIT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boot_sel_i,
  input  logic [7:0]    rx_data_i,
  input  logic          rx_valid_i,
  output logic          ram_we_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [7:0]    ram_wdata_o,
  output logic          done_o,
  output logic [AW-1:0] exec_addr_o
);
  ld_state_e     state_q, state_d;
  logic          accept;
  logic          last;
  logic          expire;
  logic [AW-1:0] ptr;

  assign accept = rx_valid_i && (state_q == LD_WAIT || state_q == LD_LOAD);

  boot_ld_addr #(.RAM_DEPTH(RAM_DEPTH), .AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .ptr_o(ptr), .last_o(last)
  );

  boot_ld_idle #(.IDLE_LIMIT(IDLE_LIMIT), .CW(CW)) u_idle (
    .clk(clk), .rst_n(rst_n), .arm_i(state_q == LD_LOAD), .kick_i(accept),
    .expire_o(expire)
  );

  boot_ld_wport #(.AW(AW)) u_wport (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .ptr_i(ptr), .data_i(rx_data_i),
    .we_o(ram_we_o), .addr_o(ram_addr_o), .wdata_o(ram_wdata_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LD_PROBE: state_d = boot_sel_i ? LD_WAIT : LD_OFF;
      LD_WAIT:  if (accept) state_d = last ? LD_DONE : LD_LOAD;
      LD_LOAD:  if ((accept && last) || expire) state_d = LD_DONE;
      LD_DONE:  state_d = LD_DONE;
      LD_OFF:   state_d = LD_OFF;
      default:  state_d = LD_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LD_PROBE;
    else state_q <= state_d;
  end

  assign done_o      = (state_q == LD_DONE);
  assign exec_addr_o = '0;

  p_off_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == LD_OFF |=> !ram_we_o && !done_o);
  p_we_from_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o |-> $past(rx_valid_i));
  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o && !ram_we_o);
  p_wait_no_timeout_r5: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == LD_WAIT && !rx_valid_i |=> !done_o);
endmodule

// File: tb/tb_serial_boot_loader.sv
`timescale 1ns/1ps
module tb_serial_boot_loader;
  localparam int DEPTH = 16;
  localparam int BITC  = 2;
  localparam int CHARB = 10;
  localparam int LIMIT = 4 * CHARB * BITC;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          boot_sel = 1'b0;
  logic [7:0]    rx_data = '0;
  logic          rx_valid = 1'b0;
  logic          we;
  logic [AW-1:0] addr;
  logic [7:0]    wdata;
  logic          done;
  logic [AW-1:0] exec_addr;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  serial_boot_loader #(.RAM_DEPTH(DEPTH), .BIT_CYCLES(BITC), .CHAR_BITS(CHARB)) dut (
    .clk(clk), .rst_n(rst_n), .boot_sel_i(boot_sel), .rx_data_i(rx_data),
    .rx_valid_i(rx_valid), .ram_we_o(we), .ram_addr_o(addr), .ram_wdata_o(wdata),
    .done_o(done), .exec_addr_o(exec_addr)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  // All tasks start and end just after a falling edge.
  task automatic do_reset(input logic b);
    @(negedge clk);
    rst_n = 1'b0; boot_sel = b; rx_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(we == 1'b0, "R7 we in reset", int'(we), 0);
    chk(done == 1'b0, "R7 done in reset", int'(done), 0);
    chk(exec_addr == '0, "R7 exec addr in reset", int'(exec_addr), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input int exp_addr, input logic exp_done);
    rx_valid = 1'b1; rx_data = d;
    @(posedge clk); #1;
    rx_valid = 1'b0;
    chk(we == 1'b1, "R2 write enable", int'(we), 1);
    chk(int'(addr) == exp_addr, "R2 write address", int'(addr), exp_addr);
    chk(wdata == d, "R2 write data", int'(wdata), int'(d));
    chk(done == exp_done, "R3 R4 done with write", int'(done), int'(exp_done));
    @(negedge clk);
  endtask

  task automatic send_ign(input logic [7:0] d, input logic exp_done, input string req);
    rx_valid = 1'b1; rx_data = d;
    @(posedge clk); #1;
    rx_valid = 1'b0;
    @(posedge clk); #1;
    chk(we == 1'b0, req, int'(we), 0);
    chk(done == exp_done, req, int'(done), int'(exp_done));
    chk(exec_addr == '0, "R6 exec address", int'(exec_addr), 0);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      chk(we == 1'b0, "R2 no write while idle", int'(we), 0);
      @(negedge clk);
    end
  endtask

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'((i * 37 + seed * 11 + 5) & 255);
  endfunction

  initial begin
    // Full load, long wait before first byte, varied gaps
    do_reset(1'b1);
    idle(3 * LIMIT);
    chk(done == 1'b0, "R5 no timeout before first byte", int'(done), 0);
    for (int i = 0; i < DEPTH; i++) begin
      send(pat(i, 1), i, (i == DEPTH - 1));
      if (i % 3 == 1) idle(3);
      else if (i % 3 == 2) idle(LIMIT - 1);
    end
    for (int j = 0; j < 3; j++) send_ign(pat(j, 7), 1'b1, "R6 byte after full load ignored");
    idle(2 * LIMIT);
    chk(done == 1'b1, "R6 done sticky", int'(done), 1);

    // Timeout boundary and restart by a strobe on the last cycle
    do_reset(1'b1);
    for (int i = 0; i < 3; i++) send(pat(i, 2), i, 1'b0);
    idle(LIMIT - 1);
    chk(done == 1'b0, "R4 gap of LIMIT accepted", int'(done), 0);
    send(pat(3, 2), 3, 1'b0);
    idle(LIMIT - 1);
    chk(done == 1'b0, "R4 no done one cycle early", int'(done), 0);
    idle(1);
    chk(done == 1'b1, "R4 done at idle limit", int'(done), 1);
    send_ign(8'hA5, 1'b1, "R6 byte after timeout ignored");

    // Single byte then timeout; address restarts from 0 after reset
    do_reset(1'b1);
    send(8'h3C, 0, 1'b0);
    idle(LIMIT - 1);
    chk(done == 1'b0, "R4 single byte before limit", int'(done), 0);
    idle(1);
    chk(done == 1'b1, "R4 single byte timeout", int'(done), 1);

    // Non-boot mode, boot select raised afterwards
    do_reset(1'b0);
    boot_sel = 1'b1;
    for (int i = 0; i < DEPTH + 4; i++) send_ign(pat(i, 3), 1'b0, "R1 not boot mode");
    idle(LIMIT + 5);
    chk(done == 1'b0, "R1 no done outside boot mode", int'(done), 0);

    // Strobe on the probe edge is not taken
    @(negedge clk);
    rst_n = 1'b0; boot_sel = 1'b1; rx_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; rx_valid = 1'b1; rx_data = 8'h77;
    @(posedge clk); #1;
    rx_valid = 1'b0;
    @(posedge clk); #1;
    chk(we == 1'b0, "R1 probe edge strobe not taken", int'(we), 0);
    @(negedge clk);
    send(8'h19, 0, 1'b0);

    finish_run();
  end
endmodule